// File: doc/BRIEF.md
# Paged Address Translator with Two-Level Table Walk

This block translates 24-bit virtual addresses into 32-bit physical addresses. A processor presents a virtual address on a request port. A small, fully associative translation buffer answers it in the same cycle when the page is already cached. On a miss, the block stalls the request. It then reads two dependent page-table words from main memory through a request/response read port, writes the result into the buffer, and completes the request.

The page table has two levels. The upper 6 bits of the 12-bit page number select a word in the top-level table, whose page address sits in a base register. That word points at a second-level table page. The lower 6 bits select a word there, and that word holds the physical page. When the top-level word is marked invalid, the second-level table does not exist and the request ends in a translation fault.

Software switches address spaces by writing the base register. That single write empties the whole buffer. If a walk is in progress, the write aborts it, and the held request is walked again under the new table.

Top module: `tlb_walker`

## Requirements
- R1: When the page of a presented request is cached, `respValid` and `reqReady` rise in that same cycle, `respFault` stays low and no memory read is issued. After reset no response and no memory read are pending.
- R2: Bits [11:0] of a successful `respPaddr` equal bits [11:0] of `reqVaddr`.
- R3: On a miss, `reqReady` stays low and exactly two reads are issued. The first goes to base + 4*vaddr[23:18]. The second goes to {word1[31:12], 12'h000} + 4*vaddr[17:12]. The response is {word2[31:12], vaddr[11:0]}. Each table word is valid when its bit 0 is 1, and every read address is word aligned.
- R4: A cycle with `baseWe` high loads `baseData[31:12]` as the table base and invalidates every buffer entry. A request presented in that same cycle is not served from the buffer, and later requests miss until they are refilled.
- R5: A top-level word with bit 0 clear ends the request after one read. `respValid` and `respFault` are high together for one cycle, `respPaddr` is zero, and no second read is issued.
- R6: A second-level word with bit 0 clear raises the same fault after two reads and writes no buffer entry, so a retry of that page walks again.
- R7: A refill writes the lowest-numbered invalid entry. When all entries are valid, it writes the entry chosen by a rotating pointer that starts at entry 0 after reset and steps by one on each such replacement.
- R8: A `baseWe` during a walk aborts it. Any outstanding read response is discarded, and the held request is walked again from the new base.
- R9: A read request that is not accepted keeps `memRdValid` high and `memRdAddr` unchanged in the next cycle, unless the walk is aborted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Translation request present; held until `reqReady` |
| reqVaddr | input | 24 | Virtual address |
| reqReady | output | 1 | Request consumed this cycle |
| respValid | output | 1 | Response valid this cycle |
| respPaddr | output | 32 | Physical address (zero on fault) |
| respFault | output | 1 | Translation fault |
| baseWe | input | 1 | Write the table base register and flush the buffer |
| baseData | input | 32 | New table base; bits [31:12] used |
| memRdValid | output | 1 | Memory read request |
| memRdReady | input | 1 | Memory accepts the read |
| memRdAddr | output | 32 | Read word address |
| memRespValid | input | 1 | Read data returned |
| memRespData | input | 32 | Table word read |

## Verification
Two functions can meet in one cycle. A lookup that would hit can coincide with a base-register write, and a walk in flight can coincide with a base-register write. The bench provokes the first by raising `baseWe` together with a request for a cached page. It judges the result by the absence of a response in that cycle, followed by a full two-read walk against the new table. It provokes the second by writing the base after the first walk read is accepted, while the memory holds that response back for three cycles. The bench expects one discarded read, followed by two reads under the new base and the new table's physical page.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_L1_REQ,
    ST_L1_WAIT,
    ST_L2_REQ,
    ST_L2_WAIT,
    ST_FAULT
  } walkState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic selL2;     // address the second-level table
    logic latchTbl;  // capture second-level table page from response
    logic fill;      // write a buffer entry from response
  } tlbStrobe_t;

endpackage

// File: rtl/tlb_datapath.sv
module tlb_datapath
  import tlb_pkg::*;
#(
  parameter int VA_W    = 24,
  parameter int OFF_W   = 12,
  parameter int L1_W    = 6,
  parameter int PA_W    = 32,
  parameter int ENTRIES = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              baseWe,
  input  logic [PA_W-1:0]   baseData,
  input  logic [VA_W-1:0]   vaddr,
  input  logic [PA_W-1:0]   memRespData,
  input  tlbStrobe_t        ctl,
  output logic              hit,
  output logic [PA_W-1:0]   hitPaddr,
  output logic [PA_W-1:0]   memRdAddr,
  output logic              pteValid
);
  localparam int VPN_W = VA_W - OFF_W;
  localparam int L2_W  = VPN_W - L1_W;
  localparam int PPN_W = PA_W - OFF_W;
  localparam int IX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [PPN_W-1:0] basePg, tblPg;
  logic [ENTRIES-1:0] entValid, matchVec;
  logic [VPN_W-1:0] entTag [ENTRIES];
  logic [PPN_W-1:0] entPpn [ENTRIES];
  logic [IX_W-1:0]  rrPtr, victim;
  logic [PPN_W-1:0] hitPpn;
  logic             allValid;

  logic [VPN_W-1:0] vpn;
  logic [L1_W-1:0]  l1Idx;
  logic [L2_W-1:0]  l2Idx;
  logic             unusedLow;

  assign vpn   = vaddr[VA_W-1:OFF_W];
  assign l1Idx = vpn[VPN_W-1:L2_W];
  assign l2Idx = vpn[L2_W-1:0];
  assign unusedLow = ^{baseData[OFF_W-1:0], memRespData[OFF_W-1:1]};

  for (genvar g = 0; g < ENTRIES; g++) begin : g_match
    assign matchVec[g] = entValid[g] && (entTag[g] == vpn);
  end

  always_comb begin
    hitPpn = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (matchVec[i]) hitPpn |= entPpn[i];
  end

  assign hit      = |matchVec;
  assign hitPaddr = {hitPpn, vaddr[OFF_W-1:0]};
  assign allValid = &entValid;

  // lowest invalid slot, else rotating pointer
  always_comb begin
    victim = rrPtr;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (!entValid[i]) victim = IX_W'(i);
  end

  always_comb begin
    if (ctl.selL2)
      memRdAddr = {tblPg, {OFF_W{1'b0}}} + (PA_W'(l2Idx) << 2);
    else
      memRdAddr = {basePg, {OFF_W{1'b0}}} + (PA_W'(l1Idx) << 2);
  end

  assign pteValid = memRespData[0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      entValid <= '0;
      basePg   <= '0;
      tblPg    <= '0;
      rrPtr    <= '0;
    end else begin
      if (baseWe) begin
        basePg   <= baseData[PA_W-1:OFF_W];
        entValid <= '0;
      end
      if (ctl.latchTbl) tblPg <= memRespData[PA_W-1:OFF_W];
      if (ctl.fill) begin
        entValid[victim] <= 1'b1;
        entTag[victim]   <= vpn;
        entPpn[victim]   <= memRespData[PA_W-1:OFF_W];
        if (allValid)
          rrPtr <= (rrPtr == IX_W'(ENTRIES - 1)) ? '0 : rrPtr + 1'b1;
      end
    end
  end

endmodule

// File: rtl/tlb_ctrl.sv
module tlb_ctrl
  import tlb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       hit,
  input  logic       baseWe,
  input  logic       memRdReady,
  input  logic       memRespValid,
  input  logic       pteValid,
  output tlbStrobe_t ctl,
  output logic       reqReady,
  output logic       respValid,
  output logic       respFault,
  output logic       memRdValid
);
  walkState_t state, nextState;
  logic       abortPend, dropResp, hitServe;

  assign dropResp  = abortPend || baseWe;
  assign hitServe  = (state == ST_IDLE) && reqValid && hit && !baseWe;
  assign respFault = (state == ST_FAULT);
  assign respValid = hitServe || respFault;
  assign reqReady  = respValid;
  assign memRdValid = ((state == ST_L1_REQ) || (state == ST_L2_REQ)) && !baseWe;

  always_comb begin
    ctl          = '0;
    ctl.selL2    = (state == ST_L2_REQ) || (state == ST_L2_WAIT);
    ctl.latchTbl = (state == ST_L1_WAIT) && memRespValid && !dropResp && pteValid;
    ctl.fill     = (state == ST_L2_WAIT) && memRespValid && !dropResp && pteValid;
  end

  always_comb begin
    nextState = state;
    unique case (state)
      ST_IDLE:
        if (reqValid && !hit && !baseWe) nextState = ST_L1_REQ;
      ST_L1_REQ:
        if (baseWe) nextState = ST_IDLE;
        else if (memRdReady) nextState = ST_L1_WAIT;
      ST_L1_WAIT:
        if (memRespValid) begin
          if (dropResp)      nextState = ST_IDLE;
          else if (pteValid) nextState = ST_L2_REQ;
          else               nextState = ST_FAULT;
        end
      ST_L2_REQ:
        if (baseWe) nextState = ST_IDLE;
        else if (memRdReady) nextState = ST_L2_WAIT;
      ST_L2_WAIT:
        if (memRespValid) begin
          if (dropResp || pteValid) nextState = ST_IDLE;
          else                      nextState = ST_FAULT;
        end
      ST_FAULT:
        nextState = ST_IDLE;
      default:
        nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      abortPend <= 1'b0;
    end else begin
      state <= nextState;
      if ((state == ST_L1_WAIT) || (state == ST_L2_WAIT)) begin
        if (memRespValid)  abortPend <= 1'b0;
        else if (baseWe)   abortPend <= 1'b1;
      end else begin
        abortPend <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/tlb_walker.sv
module tlb_walker
  import tlb_pkg::*;
#(
  parameter int VA_W    = 24,
  parameter int OFF_W   = 12,
  parameter int L1_W    = 6,
  parameter int PA_W    = 32,
  parameter int ENTRIES = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            reqValid,
  input  logic [VA_W-1:0] reqVaddr,
  output logic            reqReady,
  output logic            respValid,
  output logic [PA_W-1:0] respPaddr,
  output logic            respFault,
  input  logic            baseWe,
  input  logic [PA_W-1:0] baseData,
  output logic            memRdValid,
  input  logic            memRdReady,
  output logic [PA_W-1:0] memRdAddr,
  input  logic            memRespValid,
  input  logic [PA_W-1:0] memRespData
);
  tlbStrobe_t      ctl;
  logic            hit, pteValid;
  logic [PA_W-1:0] hitPaddr;

  tlb_datapath #(
    .VA_W(VA_W), .OFF_W(OFF_W), .L1_W(L1_W), .PA_W(PA_W), .ENTRIES(ENTRIES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .baseWe(baseWe), .baseData(baseData),
    .vaddr(reqVaddr), .memRespData(memRespData), .ctl(ctl),
    .hit(hit), .hitPaddr(hitPaddr), .memRdAddr(memRdAddr), .pteValid(pteValid)
  );

  tlb_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .hit(hit), .baseWe(baseWe),
    .memRdReady(memRdReady), .memRespValid(memRespValid), .pteValid(pteValid),
    .ctl(ctl), .reqReady(reqReady), .respValid(respValid),
    .respFault(respFault), .memRdValid(memRdValid)
  );

  assign respPaddr = respFault ? '0 : hitPaddr;

endmodule

// File: rtl/tlb_checker.sv
module tlb_checker #(
  parameter int VA_W  = 24,
  parameter int OFF_W = 12,
  parameter int PA_W  = 32
) (
  input logic            clk,
  input logic            rstN,
  input logic [VA_W-1:0] reqVaddr,
  input logic            respValid,
  input logic [PA_W-1:0] respPaddr,
  input logic            respFault,
  input logic            baseWe,
  input logic            memRdValid,
  input logic            memRdReady,
  input logic [PA_W-1:0] memRdAddr
);
  logic unusedHi;
  assign unusedHi = ^reqVaddr[VA_W-1:OFF_W];

  AST_FAULT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    respFault |-> (respValid && respPaddr == '0)); // R5

  AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && !respFault) |-> (respPaddr[OFF_W-1:0] == reqVaddr[OFF_W-1:0])); // R2

  AST_FLUSH_NO_HIT: assert property (@(posedge clk) disable iff (!rstN)
    baseWe |=> !respValid); // R4

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (memRdValid && !memRdReady) |=> (baseWe || (memRdValid && $stable(memRdAddr)))); // R9

  AST_RD_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    memRdValid |-> (memRdAddr[1:0] == 2'b00)); // R3

  AST_NO_RD_WHILE_RESP: assert property (@(posedge clk) disable iff (!rstN)
    memRdValid |-> !respValid); // R3

endmodule

bind tlb_walker tlb_checker #(.VA_W(VA_W), .OFF_W(OFF_W), .PA_W(PA_W)) u_chk (
  .clk(clk), .rstN(rstN), .reqVaddr(reqVaddr), .respValid(respValid),
  .respPaddr(respPaddr), .respFault(respFault), .baseWe(baseWe),
  .memRdValid(memRdValid), .memRdReady(memRdReady), .memRdAddr(memRdAddr)
);

// File: tb/tlb_walker_tb.sv
module tlb_walker_tb;
  localparam int CLK_P = 10;
  localparam int NE    = 8;

  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid;
  logic [23:0] reqVaddr;
  logic        reqReady, respValid, respFault;
  logic [31:0] respPaddr;
  logic        baseWe;
  logic [31:0] baseData;
  logic        memRdValid, memRdReady, memRespValid;
  logic [31:0] memRdAddr, memRespData;

  always #(CLK_P/2) clk = ~clk;

  tlb_walker u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqVaddr(reqVaddr),
    .reqReady(reqReady), .respValid(respValid), .respPaddr(respPaddr),
    .respFault(respFault), .baseWe(baseWe), .baseData(baseData),
    .memRdValid(memRdValid), .memRdReady(memRdReady), .memRdAddr(memRdAddr),
    .memRespValid(memRespValid), .memRespData(memRespData)
  );

  int checks = 0, fails = 0;
  logic [31:0] memA [int];
  logic [31:0] rdLog [$];
  int  lat = 1;
  bit  stallTog = 0, busy = 0, stalled = 0;
  int  cnt = 0;
  logic [31:0] pendA, stallA;

  // behavioural model of buffer contents
  bit          mV [NE];
  logic [11:0] mTag [NE];
  int          mRr = 0;
  logic [31:0] curBase = 0;

  localparam logic [31:0] BASE0 = 32'h0010_0000;
  localparam logic [31:0] BASE1 = 32'h0030_0000;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rd(input logic [31:0] a);
    return memA.exists(int'(a)) ? memA[int'(a)] : 32'h0;
  endfunction

  function automatic void setMap(input logic [31:0] b, input logic [11:0] vpn,
                                 input logic [19:0] ppn);
    logic [31:0] tbl;
    tbl = b + 32'h0001_0000 + {14'd0, vpn[11:6], 12'h000};
    memA[int'(b + {24'd0, vpn[11:6], 2'b00})]   = {tbl[31:12], 12'h001};
    memA[int'(tbl + {24'd0, vpn[5:0], 2'b00})] = {ppn, 12'h001};
  endfunction

  function automatic void walk(input logic [31:0] b, input logic [23:0] va,
                               output int n, output logic [31:0] a1,
                               output logic [31:0] a2, output logic [31:0] pa,
                               output bit f);
    logic [31:0] e1, e2;
    a1 = b + {24'd0, va[23:18], 2'b00};
    e1 = rd(a1); n = 1; a2 = '0; pa = '0; f = 1;
    if (!e1[0]) return;
    a2 = {e1[31:12], 12'h000} + {24'd0, va[17:12], 2'b00};
    e2 = rd(a2); n = 2;
    if (!e2[0]) return;
    f = 0; pa = {e2[31:12], va[11:0]};
  endfunction

  function automatic int mFind(input logic [11:0] t);
    for (int i = 0; i < NE; i++) if (mV[i] && mTag[i] == t) return i;
    return -1;
  endfunction

  function automatic void mFlush();
    for (int i = 0; i < NE; i++) mV[i] = 0;
  endfunction

  function automatic void mFill(input logic [11:0] t);
    int idx = -1;
    for (int i = 0; i < NE; i++) if (!mV[i] && idx < 0) idx = i;
    if (idx < 0) begin idx = mRr; mRr = (mRr + 1) % NE; end
    mV[idx] = 1; mTag[idx] = t;
  endfunction

  // memory responder: refuses every other read attempt, then answers after lat cycles
  initial begin
    memRdReady = 0; memRespValid = 0; memRespData = 0;
    forever begin
      @(negedge clk); #2;
      memRespValid = 0;
      if (busy) begin
        memRdReady = 0;
        cnt--;
        if (cnt == 0) begin memRespValid = 1; memRespData = rd(pendA); busy = 0; end
      end else if (memRdValid) begin
        if (stalled) chk(memRdAddr == stallA, "R9", "held read address", memRdAddr, stallA);
        stallTog = !stallTog;
        memRdReady = stallTog;
        if (stallTog) begin
          rdLog.push_back(memRdAddr); pendA = memRdAddr; busy = 1; cnt = lat; stalled = 0;
        end else begin
          stalled = 1; stallA = memRdAddr;
        end
      end else begin
        memRdReady = 0; stalled = 0;
      end
    end
  end

  task automatic baseWrite(input logic [31:0] b);
    @(negedge clk); baseWe = 1; baseData = b;
    @(negedge clk); baseWe = 0;
    mFlush(); curBase = b;
  endtask

  task automatic doXlate(input logic [23:0] va, input string rq, input bit withFlush,
                         input int abortAfter, input logic [31:0] nb);
    int cyc = 0, pre = 0, n;
    bit got = 0, predHit, abortDone = 0, f;
    logic [31:0] a1, a2, pa;
    rdLog.delete();
    if (withFlush) begin mFlush(); curBase = nb; end
    predHit = (mFind(va[23:12]) >= 0);
    @(negedge clk);
    reqValid = 1; reqVaddr = va;
    if (withFlush) begin baseWe = 1; baseData = nb; end
    while (!got && cyc < 400) begin
      #3;
      if (withFlush && cyc == 0)
        chk(!respValid, "R4", "served during base write", {31'd0, respValid}, 32'd0);
      if (respValid) got = 1;
      else begin
        @(negedge clk);
        baseWe = 0; cyc++;
        if (abortAfter >= 0 && !abortDone && rdLog.size() >= abortAfter) begin
          baseWe = 1; baseData = nb; abortDone = 1;
          mFlush(); curBase = nb; pre = rdLog.size();
        end
      end
    end
    walk(curBase, va, n, a1, a2, pa, f);
    chk(got, rq, "response seen", {31'd0, got}, 32'd1);
    if (predHit) begin
      chk(cyc == 0, "R1", "hit latency", cyc, 0);
      chk(rdLog.size() == 0, "R1", "reads on hit", rdLog.size(), 0);
    end else begin
      chk(cyc > 0, "R3", "miss must stall", cyc, 1);
      chk(rdLog.size() == pre + n, rq, "read count", rdLog.size(), pre + n);
      if (rdLog.size() == pre + n) begin
        chk(rdLog[pre] == a1, rq, "first read address", rdLog[pre], a1);
        if (n == 2) chk(rdLog[pre+1] == a2, rq, "second read address", rdLog[pre+1], a2);
      end
    end
    chk(respFault == f, rq, "fault flag", {31'd0, respFault}, {31'd0, f});
    chk(respPaddr == pa, rq, "physical address", respPaddr, pa);
    chk(reqReady == respValid, rq, "ready with response", {31'd0, reqReady}, {31'd0, respValid});
    @(negedge clk);
    reqValid = 0;
    if (!predHit && !f) mFill(va[23:12]);
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog run did not finish actual=%h expected=%h", 32'd1, 32'd0);
    finishRun();
  end

  initial begin
    rstN = 0; reqValid = 0; reqVaddr = '0; baseWe = 0; baseData = '0;
    setMap(BASE0, 12'h041, 20'h12345);
    for (int i = 0; i < 10; i++) setMap(BASE0, 12'h200 + 12'(i), 20'h50000 + 20'(i));
    setMap(BASE1, 12'h041, 20'hABCDE);
    setMap(BASE1, 12'h201, 20'h60001);
    repeat (3) @(negedge clk);
    #3;
    chk(!respValid && !reqReady, "R1", "reset: no response", {31'd0, respValid}, 32'd0);
    chk(!memRdValid, "R1", "reset: no read", {31'd0, memRdValid}, 32'd0);
    rstN = 1;
    baseWrite(BASE0);

    doXlate(24'h041A5C, "R3", 0, -1, 0);           // two-level walk
    doXlate(24'h041003, "R2", 0, -1, 0);           // hit, new offset
    doXlate(24'hFC0123, "R5", 0, -1, 0);           // top level invalid
    doXlate(24'hFC0FFF, "R5", 0, -1, 0);
    doXlate(24'h07F456, "R6", 0, -1, 0);           // second level invalid
    doXlate(24'h07F456, "R6", 0, -1, 0);           // walks again: no fill

    // fill all slots, then rotate replacement
    for (int i = 0; i < 10; i++) doXlate({12'h200 + 12'(i), 12'h010}, "R7", 0, -1, 0);
    doXlate(24'h041222, "R7", 0, -1, 0);           // evicted by rotation
    doXlate(24'h203333, "R7", 0, -1, 0);           // still resident
    doXlate(24'h200444, "R7", 0, -1, 0);           // evicted

    baseWrite(BASE1);
    doXlate(24'h041000, "R4", 0, -1, 0);           // misses under new base
    doXlate(24'h041777, "R4", 1, -1, BASE0);       // base write with a hit-able lookup

    lat = 3;
    doXlate(24'h2010F0, "R8", 0, 1, BASE1);        // abort in flight
    lat = 1;
    doXlate(24'h201ABC, "R8", 0, -1, 0);           // refilled under new base

    finishRun();
  end

endmodule